// File: doc/BRIEF.md
# Weekday/Time Alarm Comparator with Masked Interrupt

This block watches the running time of day (BCD seconds, minutes, hours with a PM indicator) and a weekday number, all supplied by counters outside it. It compares them with two programmable alarm words. Each of the four alarm fields carries its own enable bit. The alarm condition holds when every enabled field equals its live counter. Enabling only a subset gives a repeating alarm: seconds alone gives one alarm a minute, and seconds with minutes gives one an hour.

The alarm is one of three sticky status flags. The other two are an update-acknowledge flag and a second-event flag, and both are set by single-cycle pulses from neighbouring logic. Software clears a flag by writing 1 to its bit in a clear-command word. Interrupt enables live in a mask that is read-only. It is changed only through a set-command word and a clear-command word. The single active-high interrupt line is the OR of every flag gated by its mask bit.

A small edge-detecting state machine raises the alarm flag. In state `ARM_WAIT`, a match fires a one-cycle set pulse and takes the transition `FIRE` into `ARM_HIT`. In `ARM_HIT` no further pulse is issued. The transition `REARM` returns it to `ARM_WAIT` once the match ends. A match that lasts a whole second therefore sets the flag only once, and a clear during that second sticks.

Top module: `alm_irq_ctrl`

## Requirements
- R1: After reset the time alarm word (index 0) reads 0x00000000, the weekday alarm word (index 1) reads 0x00000100, the status word (index 2) and the mask (index 6) read 0, and `irq` is 0.
- R2: Time alarm layout: second in bits 6:0 with enable 7, minute in 14:8 with enable 15, hour in 21:16, PM in 22, hour enable 23. Weekday alarm layout: day in 10:8 with enable 15. When every enabled field (hour and PM compared together) equals its input, status bit 1 sets one cycle later.
- R3: With only the second field enabled, the alarm sets whenever the seconds input equals it, whatever the other inputs are.
- R4: With all four enables at 0, no alarm flag is raised even when the field values equal the inputs.
- R5: The alarm flag sets only when a match begins. After it is cleared during a continuing match, it stays 0 until the match ends and begins again.
- R6: A pulse on `upd_ack_evt` sets status bit 0 and a pulse on `sec_evt` sets status bit 2. Both stay set until cleared.
- R7: Writing to index 3 clears every status flag whose data bit is 1. Data bits at 0 leave their flags unchanged.
- R8: When a flag's set event and its clear command fall in the same cycle, the flag ends set.
- R9: A write to index 4 sets the mask bits given as 1, and a write to index 5 clears them. Mask bits 0/1/2 gate status bits 0/1/2. A write to index 6 has no effect.
- R10: `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R11: Indices 3, 4, 5 and 7 read 0. Undefined bits of the alarm words read 0: the time word keeps bits 23:0 and the weekday word keeps bits 15 and 10:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (3) | Word index of the register accessed |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| now_sec | input | 7 | Live BCD seconds |
| now_min | input | 7 | Live BCD minutes |
| now_hour | input | 6 | Live BCD hour |
| now_pm | input | 1 | Live PM indicator |
| now_day | input | 3 | Live weekday number |
| upd_ack_evt | input | 1 | One-cycle pulse: update acknowledge occurred |
| sec_evt | input | 1 | One-cycle pulse: a second elapsed |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters, DATA_W of 32 and ADDR_W of 3. At that width the three-bit index reaches all seven defined registers and one unmapped index, so the zero read of an undefined address is exercised. The full 32-bit write data also lets the bench write all ones and observe that only the defined alarm bits are kept.

// File: rtl/alm_irq_pkg.sv
package alm_irq_pkg;

    localparam int N_FLAGS = 3;

    // status / mask bit positions
    localparam int FLG_UPD = 0;
    localparam int FLG_ALM = 1;
    localparam int FLG_SEC = 2;

    // register word indices
    localparam int IDX_TALM = 0;
    localparam int IDX_DALM = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_SCLR = 3;
    localparam int IDX_IEN  = 4;
    localparam int IDX_IDIS = 5;
    localparam int IDX_IMSK = 6;

    // time alarm word layout
    localparam int TA_W      = 24;
    localparam int TA_SEC_LO = 0;
    localparam int TA_SEC_EN = 7;
    localparam int TA_MIN_LO = 8;
    localparam int TA_MIN_EN = 15;
    localparam int TA_HR_LO  = 16;
    localparam int TA_PM     = 22;
    localparam int TA_HR_EN  = 23;

    // weekday alarm word layout
    localparam int DA_DAY_LO = 8;
    localparam int DA_DAY_EN = 15;
    localparam logic [15:0] DA_KEEP  = 16'h8700;
    localparam logic [15:0] DA_RESET = 16'h0100;

    typedef enum logic [0:0] {
        ARM_WAIT = 1'b0,
        ARM_HIT  = 1'b1
    } arm_state_t;

endpackage

// File: rtl/alm_matcher.sv
module alm_matcher
    import alm_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TA_W-1:0] talm_i,
    input  logic [15:0]     dalm_i,
    input  logic [6:0]      now_sec_i,
    input  logic [6:0]      now_min_i,
    input  logic [5:0]      now_hour_i,
    input  logic            now_pm_i,
    input  logic [2:0]      now_day_i,
    output logic            hit_o
);

    logic [3:0] fld_en;
    logic [3:0] fld_eq;
    logic       any_en;
    logic       match;

    always_comb begin
        fld_en[0] = talm_i[TA_SEC_EN];
        fld_en[1] = talm_i[TA_MIN_EN];
        fld_en[2] = talm_i[TA_HR_EN];
        fld_en[3] = dalm_i[DA_DAY_EN];
        fld_eq[0] = (talm_i[TA_SEC_LO +: 7] == now_sec_i);
        fld_eq[1] = (talm_i[TA_MIN_LO +: 7] == now_min_i);
        fld_eq[2] = ({talm_i[TA_PM], talm_i[TA_HR_LO +: 6]} == {now_pm_i, now_hour_i});
        fld_eq[3] = (dalm_i[DA_DAY_LO +: 3] == now_day_i);
    end

    // a field passes when disabled or equal
    logic [3:0] fld_ok;
    for (genvar f = 0; f < 4; f++) begin : g_fld
        assign fld_ok[f] = ~fld_en[f] | fld_eq[f];
    end

    assign any_en = |fld_en;
    assign match  = any_en & (&fld_ok);

    arm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        unique case (state_q)
            ARM_WAIT: if (match) begin      // FIRE
                hit_o   = 1'b1;
                state_d = ARM_HIT;
            end
            ARM_HIT: if (!match) begin      // REARM
                state_d = ARM_WAIT;
            end
            default: state_d = ARM_WAIT;
        endcase
    end

    // R5: a match start yields a single set pulse
    a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);

    // R4: no pulse while every field is disabled
    a_r4_no_enable_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_en == 4'b0) |-> !hit_o);

endmodule

// File: rtl/alm_flag_bank.sv
module alm_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar k = 0; k < N; k++) begin : g_flag
        logic flag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[k]) flag_q <= 1'b1;
            else if (clr_i[k]) flag_q <= 1'b0;
        end

        assign flag_o[k] = flag_q;

        // R7: a clear without a set empties the flag
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flag_o[k]);

        // R8: a set wins over a clear in the same cycle
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flag_o[k]);

        // R6: a flag without set or clear holds its value
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[k] && !clr_i[k]) |=> $stable(flag_o[k]));
    end

endmodule

// File: rtl/alm_mask_bank.sv
module alm_mask_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we_i,
    input  logic         dis_we_i,
    input  logic [N-1:0] bits_i,
    output logic [N-1:0] mask_o
);

    logic [N-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '0;
        else if (en_we_i)  mask_q <= mask_q | bits_i;
        else if (dis_we_i) mask_q <= mask_q & ~bits_i;
    end

    assign mask_o = mask_q;

    // R9: enable command raises the named bits
    a_r9_enable: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> ((mask_o & $past(bits_i)) == $past(bits_i)));

    // R9: disable command drops the named bits
    a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_we_i && !en_we_i) |=> ((mask_o & $past(bits_i)) == '0));

    // R9: without a command the mask holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_we_i && !dis_we_i) |=> $stable(mask_o));

endmodule

// File: rtl/alm_irq_ctrl.sv
module alm_irq_ctrl
    import alm_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [6:0]        now_sec,
    input  logic [6:0]        now_min,
    input  logic [5:0]        now_hour,
    input  logic              now_pm,
    input  logic [2:0]        now_day,
    input  logic              upd_ack_evt,
    input  logic              sec_evt,
    output logic              irq
);

    localparam int N_IDX = 1 << ADDR_W;

    // one-hot write decode
    logic [N_IDX-1:0] wr_hit;
    for (genvar i = 0; i < N_IDX; i++) begin : g_dec
        assign wr_hit[i] = reg_we && (reg_addr == ADDR_W'(i));
    end

    // alarm words
    logic [TA_W-1:0] talm_q;
    logic [15:0]     dalm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            talm_q <= '0;
            dalm_q <= DA_RESET;
        end else begin
            if (wr_hit[IDX_TALM]) talm_q <= reg_wdata[TA_W-1:0];
            if (wr_hit[IDX_DALM]) dalm_q <= reg_wdata[15:0] & DA_KEEP;
        end
    end

    logic alm_hit;

    alm_matcher u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .talm_i     (talm_q),
        .dalm_i     (dalm_q),
        .now_sec_i  (now_sec),
        .now_min_i  (now_min),
        .now_hour_i (now_hour),
        .now_pm_i   (now_pm),
        .now_day_i  (now_day),
        .hit_o      (alm_hit)
    );

    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_clr;
    logic [N_FLAGS-1:0] status;
    logic [N_FLAGS-1:0] mask;

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_UPD] = upd_ack_evt;
        flag_set[FLG_ALM] = alm_hit;
        flag_set[FLG_SEC] = sec_evt;
        flag_clr          = wr_hit[IDX_SCLR] ? reg_wdata[N_FLAGS-1:0] : '0;
    end

    alm_flag_bank #(.N(N_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (status)
    );

    alm_mask_bank #(.N(N_FLAGS)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we_i  (wr_hit[IDX_IEN]),
        .dis_we_i (wr_hit[IDX_IDIS]),
        .bits_i   (reg_wdata[N_FLAGS-1:0]),
        .mask_o   (mask)
    );

    assign irq = |(status & mask);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(IDX_TALM): reg_rdata[TA_W-1:0]    = talm_q;
            ADDR_W'(IDX_DALM): reg_rdata[15:0]        = dalm_q;
            ADDR_W'(IDX_STAT): reg_rdata[N_FLAGS-1:0] = status;
            ADDR_W'(IDX_IMSK): reg_rdata[N_FLAGS-1:0] = mask;
            default:           reg_rdata              = '0;
        endcase
    end

    // R1: nothing is pending right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (status == '0) && (mask == '0));

    // R10: a masked flag that stays set keeps the request up
    a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_we) |=> irq);

endmodule

// File: tb/alm_irq_ctrl_test.sv
`timescale 1ns/1ps
module alm_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  now_sec = '0;
    logic [6:0]  now_min = '0;
    logic [5:0]  now_hour = '0;
    logic        now_pm = 1'b0;
    logic [2:0]  now_day = '0;
    logic        upd_ack_evt = 1'b0;
    logic        sec_evt = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    alm_irq_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .now_sec     (now_sec),
        .now_min     (now_min),
        .now_hour    (now_hour),
        .now_pm      (now_pm),
        .now_day     (now_day),
        .upd_ack_evt (upd_ack_evt),
        .sec_evt     (sec_evt),
        .irq         (irq)
    );

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    int          kind_q[$];
    string       tag_q[$];

    // monitor: compares just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                logic [31:0] got;
                int          k;
                string       t;
                e = exp_q.pop_front();
                k = kind_q.pop_front();
                t = tag_q.pop_front();
                got = (k == 0) ? reg_rdata : {31'b0, irq};
                n_vec++;
                if (got !== e) begin
                    n_miss++;
                    $display("FAIL %s: got %h expected %h", t, got, e);
                end
            end
        end
    end

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_addr = a;
        exp_q.push_back(e); kind_q.push_back(0); tag_q.push_back(t);
        @(posedge clk); #3;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        exp_q.push_back({31'b0, e}); kind_q.push_back(1); tag_q.push_back(t);
        @(posedge clk); #3;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                            input logic [5:0] h, input logic pm, input logic [2:0] d);
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; now_pm = pm; now_day = d;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        chk_reg(3'd0, 32'h0000_0000, "R1 time alarm reset");
        chk_reg(3'd1, 32'h0000_0100, "R1 weekday alarm reset");
        chk_reg(3'd2, 32'h0, "R1 status reset");
        chk_reg(3'd6, 32'h0, "R1 mask reset");
        chk_irq(1'b0, "R1 irq reset");

        // R11 write-only and unmapped reads
        chk_reg(3'd3, 32'h0, "R11 clear cmd reads 0");
        chk_reg(3'd4, 32'h0, "R11 enable cmd reads 0");
        chk_reg(3'd5, 32'h0, "R11 disable cmd reads 0");
        chk_reg(3'd7, 32'h0, "R11 unmapped reads 0");

        // R9 mask set/clear and read-only
        wr(3'd4, 32'h7);
        chk_reg(3'd6, 32'h7, "R9 enable sets mask");
        wr(3'd5, 32'h2);
        chk_reg(3'd6, 32'h5, "R9 disable clears bit 1");
        wr(3'd6, 32'h0);
        chk_reg(3'd6, 32'h5, "R9 mask write ignored");
        wr(3'd5, 32'h7);
        chk_reg(3'd6, 32'h0, "R9 disable all");

        // R6 event flags
        @(negedge clk); upd_ack_evt = 1'b1; @(negedge clk); upd_ack_evt = 1'b0;
        chk_reg(3'd2, 32'h1, "R6 update ack flag");
        @(negedge clk); sec_evt = 1'b1; @(negedge clk); sec_evt = 1'b0;
        idle(2);
        chk_reg(3'd2, 32'h5, "R6 second flag sticky");

        // R10 irq gating
        chk_irq(1'b0, "R10 irq off while masked");
        wr(3'd4, 32'h1);
        chk_irq(1'b1, "R10 irq from update flag");
        wr(3'd5, 32'h1);
        chk_irq(1'b0, "R10 irq dropped by disable");
        wr(3'd4, 32'h4);
        chk_irq(1'b1, "R10 irq from second flag");

        // R7 write-one-to-clear
        wr(3'd3, 32'h0);
        chk_reg(3'd2, 32'h5, "R7 zero write no effect");
        wr(3'd3, 32'h4);
        chk_reg(3'd2, 32'h1, "R7 clear second flag");
        chk_irq(1'b0, "R10 irq off after clear");
        wr(3'd3, 32'h1);
        chk_reg(3'd2, 32'h0, "R7 clear update flag");

        // R8 set and clear together
        @(negedge clk);
        sec_evt = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h4; reg_we = 1'b1;
        @(negedge clk);
        sec_evt = 1'b0; reg_we = 1'b0;
        chk_reg(3'd2, 32'h4, "R8 set wins over clear");
        wr(3'd3, 32'h7);
        wr(3'd5, 32'h7);

        // R2 full alarm
        set_time(7'h55, 7'h34, 6'h12, 1'b0, 3'd3);
        wr(3'd0, 32'h0092_B4D6);
        chk_reg(3'd0, 32'h0092_B4D6, "R2 time alarm readback");
        wr(3'd1, 32'h0000_8300);
        chk_reg(3'd1, 32'h0000_8300, "R2 weekday alarm readback");
        chk_reg(3'd2, 32'h0, "R2 no alarm before match");
        wr(3'd4, 32'h2);
        set_time(7'h56, 7'h34, 6'h12, 1'b0, 3'd3);
        chk_reg(3'd2, 32'h2, "R2 alarm on full match");
        chk_irq(1'b1, "R10 irq from alarm");

        // R2 weekday mismatch
        wr(3'd3, 32'h2);
        set_time(7'h57, 7'h34, 6'h12, 1'b0, 3'd3);
        wr(3'd1, 32'h0000_8400);
        set_time(7'h56, 7'h34, 6'h12, 1'b0, 3'd3);
        chk_reg(3'd2, 32'h0, "R2 weekday mismatch blocks alarm");

        // R5 edge behaviour
        wr(3'd1, 32'h0000_8300);
        chk_reg(3'd2, 32'h2, "R5 alarm when match begins");
        wr(3'd3, 32'h2);
        idle(3);
        chk_reg(3'd2, 32'h0, "R5 no reset while match holds");
        set_time(7'h57, 7'h34, 6'h12, 1'b0, 3'd3);
        idle(1);
        set_time(7'h56, 7'h34, 6'h12, 1'b0, 3'd3);
        chk_reg(3'd2, 32'h2, "R5 alarm after match restarts");
        wr(3'd3, 32'h2);

        // R3 seconds only
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0000_0090);
        set_time(7'h10, 7'h07, 6'h03, 1'b0, 3'd6);
        chk_reg(3'd2, 32'h2, "R3 seconds-only first");
        wr(3'd3, 32'h2);
        set_time(7'h09, 7'h22, 6'h04, 1'b1, 3'd1);
        chk_reg(3'd2, 32'h0, "R3 no alarm off-second");
        set_time(7'h10, 7'h22, 6'h04, 1'b1, 3'd1);
        chk_reg(3'd2, 32'h2, "R3 seconds-only next minute");
        wr(3'd3, 32'h2);

        // R4 all enables off
        wr(3'd0, 32'h0);
        set_time(7'h00, 7'h00, 6'h00, 1'b0, 3'd0);
        idle(2);
        chk_reg(3'd2, 32'h0, "R4 no alarm with enables off");
        chk_irq(1'b0, "R4 irq stays low");

        // R2 PM compared with hour
        set_time(7'h00, 7'h00, 6'h05, 1'b0, 3'd0);
        wr(3'd0, 32'h00C5_0000);
        chk_reg(3'd2, 32'h0, "R2 PM mismatch blocks alarm");
        set_time(7'h00, 7'h00, 6'h05, 1'b1, 3'd0);
        chk_reg(3'd2, 32'h2, "R2 PM hour match");

        // R11 undefined bits
        wr(3'd0, 32'hFFFF_FFFF);
        chk_reg(3'd0, 32'h00FF_FFFF, "R11 time alarm kept bits");
        wr(3'd1, 32'hFFFF_FFFF);
        chk_reg(3'd1, 32'h0000_8700, "R11 weekday alarm kept bits");

        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule